// File: doc/BRIEF.md
# Serial Field Memory Read Port

This block is the read half of a serial field memory. It runs on its own read clock, which need not match the write clock in rate or phase. It keeps a read pointer into a storage array that it shares with a separate write port. On each active cycle it fetches the word at the address it is about to select and holds that word in an output register. The output register drives a 12-bit bus that can be released to high impedance. A separate flag shows when the bus is driven.

Three controls steer the reader:

- A read-reset strobe rewinds the pointer to address zero on the first read-clock edge that samples the strobe high.
- Read enable gates the clock for both the pointer and the output word. With it low, everything freezes.
- Output enable only decides whether the fetched word is driven. The pointer keeps stepping, so a reader can skip a stretch of the field while the bus is released.

The array is read combinationally. The port presents `arr_addr`, and the array returns the word stored there on `arr_data` in the same cycle. The word is captured at the next read-clock edge.

Top module: `field_rd_port`

## Requirements
- R1: While `rst` is high at a read-clock edge, the pointer is set to 0 and `dout_vld` to 0. After release, with `rd_en` and `rd_rst` low, `arr_addr` reads 0.
- R2: A read-clock edge that samples `rd_rst` high, when the previous edge sampled it low, is a rewind cycle. It sets the pointer to 0, loads the word at address 0 and sets `dout_vld` to 1, whatever the levels of `rd_en` and `out_en`. The first edge after `rst` counts as following a low sample.
- R3: Further edges on which `rd_rst` is still high are ordinary cycles. They are governed by `rd_en` and `out_en` and do not rewind again.
- R4: On an edge with `rd_en` high that is not a rewind cycle, the pointer advances by one. Before each edge, `arr_addr` shows the address that edge will select: 0 for a rewind, the incremented pointer for a step, and the current pointer for a hold.
- R5: On an edge with `rd_en` low that is not a rewind cycle, the pointer, `dout` and `dout_vld` all hold.
- R6: On a step cycle, `dout_vld` takes the level of `out_en`. With `out_en` low, `dout` is high impedance and the pointer still advances.
- R7: When `out_en` returns high after skipped cycles, the next step drives the word at the address the pointer has reached, which includes every skipped step.
- R8: The pointer wraps from DEPTH-1 to 0 on a step, including when DEPTH is not a power of two.
- R9: While `dout_vld` is 1, `dout` equals, bit for bit, the `arr_data` word fetched for the address selected at the last loading edge.
- R10: `rd_rst` must be sampled low on at least two edges before each new rewind.
- R11: At least 80 active (step) cycles must pass between one rewind and the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_rst | input | 1 | Read-reset strobe; its first high sample rewinds the pointer |
| rd_en | input | 1 | Read enable; gates the pointer and the output word |
| out_en | input | 1 | Output enable; releases the bus when low |
| arr_data | input | 12 | Word from the shared array at `arr_addr` |
| arr_addr | output | AW | Address the next edge selects (AW = clog2 DEPTH) |
| dout | output | 12 | Registered read data, high impedance when not driven |
| dout_vld | output | 1 | High when `dout` is driven |

## Verification
A rewind and an enable setting can fall on the same edge. The rewind must win: it loads address 0 and drives the bus even when `rd_en` or `out_en` is low in that cycle. The bench provokes this by issuing the read-reset strobe together with random enable levels, including both enables low. It also holds the strobe high for several edges so that the first-edge rule is separated from the ordinary cycles that follow. Each edge is judged against a bench model of the pointer and the output slot, by comparing `arr_addr` before the edge and `dout`/`dout_vld` after it.

// File: rtl/field_rd_pkg.sv
package field_rd_pkg;

    localparam int WORD_W    = 12;
    localparam int MIN_BURST = 80;
    localparam int RST_GAP   = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        RD_HOLD   = 2'd0,
        RD_STEP   = 2'd1,
        RD_REWIND = 2'd2
    } rd_op_e;

    typedef struct packed {
        word_t word;
        logic  drive;
    } out_slot_t;

    function automatic rd_op_e pick_op(input logic rewind, input logic en);
        if (rewind)
            return RD_REWIND;
        else if (en)
            return RD_STEP;
        else
            return RD_HOLD;
    endfunction

endpackage

// File: rtl/field_rd_ctl.sv
module field_rd_ctl
    import field_rd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rd_rst,
    input  logic   rd_en,
    output rd_op_e op
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst)
            strobe_q <= 1'b0;
        else
            strobe_q <= rd_rst;
    end

    assign op = pick_op(rd_rst && !strobe_q, rd_en);

endmodule

// File: rtl/field_rd_ptr.sv
module field_rd_ptr
    import field_rd_pkg::*;
#(
    parameter int DEPTH = 262144,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  rd_op_e        op,
    output logic [AW-1:0] nxt_addr,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam bit            POW2 = ((DEPTH & (DEPTH - 1)) == 0) && (DEPTH == (1 << AW));

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] inc;

    generate
        if (POW2) begin : g_natural_wrap
            assign inc = ptr_q + 1'b1;
        end else begin : g_compare_wrap
            assign inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    endgenerate

    always_comb begin
        case (op)
            RD_REWIND: nxt_addr = '0;
            RD_STEP:   nxt_addr = inc;
            default:   nxt_addr = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else
            ptr_q <= nxt_addr;
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/field_rd_outreg.sv
module field_rd_outreg
    import field_rd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rd_op_e    op,
    input  logic      out_en,
    input  word_t     arr_data,
    output out_slot_t slot
);

    out_slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '{word: '0, drive: 1'b0};
        end else begin
            case (op)
                RD_REWIND: slot_q <= '{word: arr_data, drive: 1'b1};
                RD_STEP:   slot_q <= '{word: arr_data, drive: out_en};
                default:   slot_q <= slot_q;
            endcase
        end
    end

    assign slot = slot_q;

endmodule

// File: rtl/field_rd_port.sv
module field_rd_port
    import field_rd_pkg::*;
#(
    parameter int DEPTH = 262144,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic              out_en,
    input  logic [WORD_W-1:0] arr_data,
    output logic [AW-1:0]     arr_addr,
    output logic [WORD_W-1:0] dout,
    output logic              dout_vld
);

    rd_op_e        op;
    logic [AW-1:0] ptr_w;
    out_slot_t     slot;
    word_t         cur_word;

    field_rd_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .rd_rst (rd_rst),
        .rd_en  (rd_en),
        .op     (op)
    );

    field_rd_ptr #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .nxt_addr (arr_addr),
        .ptr      (ptr_w)
    );

    field_rd_outreg u_out (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .out_en   (out_en),
        .arr_data (arr_data),
        .slot     (slot)
    );

    assign cur_word = slot.word;
    assign dout_vld = slot.drive;
    assign dout     = slot.drive ? cur_word : 'z;

endmodule

// File: rtl/field_rd_port_chk.sv
module field_rd_port_chk
    import field_rd_pkg::*;
#(
    parameter int DEPTH = 262144,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_rst,
    input logic          rd_en,
    input logic          out_en,
    input word_t         arr_data,
    input logic [AW-1:0] ptr,
    input word_t         cur_word,
    input logic          dout_vld
);

    logic     seen_q;
    logic     rewind;
    int       low_cnt;
    int       act_cnt;

    assign rewind = rd_rst && !seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            low_cnt <= RST_GAP;
            act_cnt <= MIN_BURST;
        end else begin
            seen_q  <= rd_rst;
            if (rd_rst)
                low_cnt <= 0;
            else if (low_cnt < RST_GAP)
                low_cnt <= low_cnt + 1;
            if (rewind)
                act_cnt <= 0;
            else if (rd_en && act_cnt < MIN_BURST)
                act_cnt <= act_cnt + 1;
        end
    end

    AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (ptr == '0) && dout_vld); // R2

    AST_HELD_NO_REWIND: assert property (@(posedge clk) disable iff (rst)
        (rd_rst && seen_q && !rd_en) |=> $stable(ptr)); // R3

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!rewind && !rd_en) |=> $stable(ptr) && $stable(dout_vld) && $stable(cur_word)); // R5

    AST_DRIVE_FOLLOWS_OE: assert property (@(posedge clk) disable iff (rst)
        (!rewind && rd_en) |=> (dout_vld == $past(out_en))); // R6

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!rewind && rd_en && ptr == AW'(DEPTH - 1)) |=> (ptr == '0)); // R8

    AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!rewind && rd_en) |=> (cur_word == $past(arr_data))); // R9

    AST_RST_GAP: assert property (@(posedge clk) disable iff (rst)
        rewind |-> (low_cnt >= RST_GAP)); // R10

    AST_MIN_BURST: assert property (@(posedge clk) disable iff (rst)
        rewind |-> (act_cnt >= MIN_BURST)); // R11

endmodule

bind field_rd_port field_rd_port_chk #(
    .DEPTH (DEPTH),
    .AW    (AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_rst   (rd_rst),
    .rd_en    (rd_en),
    .out_en   (out_en),
    .arr_data (arr_data),
    .ptr      (ptr_w),
    .cur_word (cur_word),
    .dout_vld (dout_vld)
);

// File: tb/field_rd_port_test.sv
module field_rd_port_test;

    localparam int DEPTH  = 200;
    localparam int AW     = $clog2(DEPTH);
    localparam int MINB   = 80;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_rst = 1'b0;
    logic          rd_en = 1'b0;
    logic          out_en = 1'b0;
    logic [11:0]   arr_data;
    logic [AW-1:0] arr_addr;
    logic [11:0]   dout;
    logic          dout_vld;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model state
    int   m_ptr  = 0;
    logic [11:0] m_data = '0;
    logic m_vld  = 1'b0;
    logic m_seen = 1'b0;
    logic m_oe_gap = 1'b0;
    int   act_since = MINB;
    int   low_run = 2;
    int   min_burst_seen = 1 << 30;
    int   min_gap_seen = 1 << 30;
    int   rewinds = 0;

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [11:0] word_at(input int a);
        int v;
        v = (a * 1103 + 417) ^ (a >> 3) ^ 12'h9C3;
        return v[11:0];
    endfunction

    assign arr_data = word_at(int'(arr_addr));

    field_rd_port #(.DEPTH(DEPTH)) uut (
        .clk      (clk),
        .rst      (rst),
        .rd_rst   (rd_rst),
        .rd_en    (rd_en),
        .out_en   (out_en),
        .arr_data (arr_data),
        .arr_addr (arr_addr),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One read-clock cycle; inputs change at the falling edge.
    task automatic cyc(input logic rr, input logic en, input logic oe);
        logic  rew;
        int    nxt;
        string tag;
        rd_rst = rr; rd_en = en; out_en = oe;
        rew = rr && !m_seen;
        if (rew)
            nxt = 0;
        else if (en)
            nxt = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
        else
            nxt = m_ptr;
        if (rew)                          tag = "R2";
        else if (rr)                      tag = "R3";
        else if (!en)                     tag = "R5";
        else if (!oe)                     tag = "R6";
        else if (m_ptr == DEPTH - 1)      tag = "R8";
        else if (m_oe_gap)                tag = "R7";
        else                              tag = "R4";
        #1;
        check({tag, " addr"}, int'(arr_addr) == nxt, int'(arr_addr), nxt);
        @(posedge clk);
        // model update
        if (rew) begin
            if (rewinds > 0 && act_since < min_burst_seen) min_burst_seen = act_since;
            if (rewinds > 0 && low_run < min_gap_seen) min_gap_seen = low_run;
            rewinds++;
            act_since = 0;
            m_data = word_at(0); m_vld = 1'b1;
        end else if (en) begin
            act_since++;
            m_data = word_at(nxt); m_vld = oe;
            m_oe_gap = !oe;
        end
        low_run = rr ? 0 : low_run + 1;
        m_ptr  = nxt;
        m_seen = rr;
        @(negedge clk);
        check({tag, " vld"}, dout_vld === m_vld, int'(dout_vld), int'(m_vld));
        if (m_vld)
            check("R9 data", dout === m_data, int'(dout), int'(m_data));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 vld", dout_vld === 1'b0, int'(dout_vld), 0);
        check("R1 addr", arr_addr == '0, int'(arr_addr), 0);

        // R2: rewind with both enables low still drives word 0
        cyc(1, 0, 0);
        // R3: strobe held high, later edges are ordinary steps
        cyc(1, 1, 1);
        cyc(1, 1, 1);
        cyc(0, 1, 1);
        // R5: hold
        cyc(0, 0, 1);
        cyc(0, 0, 0);
        // R6/R7: skip with bus released, then resume
        for (int i = 0; i < 5; i++) cyc(0, 1, 0);
        cyc(0, 1, 1);
        // R8: run past the wrap point
        for (int i = 0; i < DEPTH + 10; i++) cyc(0, 1, 1);

        // random traffic obeying R10 and R11
        for (int i = 0; i < 6000; i++) begin
            logic en, oe;
            en = ($urandom % 4) != 0;
            oe = ($urandom % 5) != 0;
            if (act_since >= MINB && low_run >= 2 && ($urandom % 30) == 0) begin
                int hold_len;
                hold_len = 1 + ($urandom % 3);
                for (int h = 0; h < hold_len; h++)
                    cyc(1, ($urandom % 2) != 0, ($urandom % 2) != 0);
            end else begin
                cyc(0, en, oe);
            end
        end

        check("R10 gap", min_gap_seen >= 2, min_gap_seen, 2);
        check("R11 burst", min_burst_seen >= MINB, min_burst_seen, MINB);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule